// File: doc/BRIEF.md
# Masked-Write Open-Drain Pin Control Register

This block is a single 32-bit control register that operates two open-drain pins, a clock pin (pin 0) and a data pin (pin 1). Each pin has its own 8-bit field in the register. Software sets each pin through a simple register bus: a write strobe with write data, and a read strobe with read data.

Within a pin's field, the direction and the output value each have an update-enable (mask) bit in the same write. A field that is not enabled keeps its stored value. Software can therefore release or pull one pin without rewriting the other.

The pads are open-drain. A pin is pulled low only when it is set as an output and its stored value is 0. Otherwise the pad is released and its pull-up sets the level, unless the pull-up is disabled. The pad levels pass through a two-flop synchronizer. Reads return those synchronized levels next to the stored configuration.

Top module: `gpio_mask_reg`

## Requirements
- R1: After reset, both pins are inputs with stored value 0 and pull-ups enabled. No pad is driven (pad_oe_o = 0) and pad_pu_en_o = 2'b11.
- R2: In pin p's field (base bit 8*p), bit 1 is the direction (1 = output). It is loaded from the write data only when bit 0 of the same field is 1 in that write; otherwise it keeps its value.
- R3: Bit 3 of a pin's field is the stored output value. It is loaded only when bit 2 of the same field is 1 in the write; otherwise it keeps its value.
- R4: Bit 5 of a pin's field disables that pin's pull-up (pad_pu_en_o[p] = 0 when the bit is set). It is loaded only by a write that has bit 0 or bit 2 of that field set.
- R5: pad_oe_o[p] is 1 exactly when pin p is an output and its stored value is 0 (open-drain pull low).
- R6: Bit 4 of a pin's field reads back the pad level after a two-flop synchronizer. This holds whether or not the pin is driven. A pad level that is stable for two clock edges is read correctly.
- R7: The mask positions (bits 0 and 2), bits 6 and 7 of each field, and bits 16 to 31 read as 0. Write data in the input-level position (bit 4) has no effect.
- R8: rd_data_o is loaded with the register image on a clock edge where rd_en_i is 1. It holds its value on all other edges and is 0 after reset.
- R9: A write whose mask bits for one pin are all 0 leaves that pin's direction, value and pull-up setting unchanged, whatever the rest of the write data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data with per-field masks |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| pad_in_i | input | 2 | Pad levels, bit 0 clock pin, bit 1 data pin |
| pad_oe_o | output | 2 | Pull pad low when 1 |
| pad_pu_en_o | output | 2 | Pull-up enable per pad |

## Verification
Random writes set and clear the mask bits in every combination. This exposes a design that loads a field without its mask, ties one mask to both fields, or lets the pull-up bit change on a mask-free write. A write of all ones checks that the input-level position cannot be forced: a design that stores it would read 1 on a low pad. A pad level that differs from the driven value tests that reads report the pad and not the register. A read taken in the cycle after a level change tests the synchronizer depth: a design with too few stages would show the new level early.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;
  localparam int unsigned FIELD_W     = 8;
  localparam int unsigned DIR_MSK_BIT = 0;
  localparam int unsigned DIR_BIT     = 1;
  localparam int unsigned VAL_MSK_BIT = 2;
  localparam int unsigned VAL_BIT     = 3;
  localparam int unsigned LVL_BIT     = 4;
  localparam int unsigned PU_DIS_BIT  = 5;

  typedef struct packed {
    logic dir_out;
    logic val;
    logic pu_dis;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            warm_q <= '0;
      else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
    AST_SYNC_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2'd2) |-> (q_o == $past(d_i, 2))); // R6
  end
endmodule

// File: rtl/gpio_pin_field.sv
module gpio_pin_field
  import gpio_ctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [FIELD_W-1:0] field_i,
  output pin_cfg_t           cfg_o
);
  logic dir_we, val_we, pu_we;
  pin_cfg_t cfg_q;

  assign dir_we = wr_en_i & field_i[DIR_MSK_BIT];
  assign val_we = wr_en_i & field_i[VAL_MSK_BIT];
  assign pu_we  = dir_we | val_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      if (dir_we) cfg_q.dir_out <= field_i[DIR_BIT];
      if (val_we) cfg_q.val     <= field_i[VAL_BIT];
      if (pu_we)  cfg_q.pu_dis  <= field_i[PU_DIS_BIT];
    end
  end

  assign cfg_o = cfg_q;

  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && field_i[DIR_MSK_BIT]) |=> $stable(cfg_o.dir_out)); // R2
  AST_VAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && field_i[VAL_MSK_BIT]) |=> $stable(cfg_o.val)); // R3
  AST_PU_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && (field_i[DIR_MSK_BIT] || field_i[VAL_MSK_BIT])) |=> $stable(cfg_o.pu_dis)); // R4
endmodule

// File: rtl/gpio_rd_pack.sv
module gpio_rd_pack
  import gpio_ctl_pkg::*;
#(
  parameter int unsigned NUM_PINS = 2,
  parameter int unsigned DATA_W   = 32
) (
  input  pin_cfg_t [NUM_PINS-1:0] cfg_i,
  input  logic     [NUM_PINS-1:0] lvl_i,
  output logic     [DATA_W-1:0]   image_o
);
  always_comb begin
    image_o = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      image_o[p*FIELD_W + DIR_BIT]    = cfg_i[p].dir_out;
      image_o[p*FIELD_W + VAL_BIT]    = cfg_i[p].val;
      image_o[p*FIELD_W + LVL_BIT]    = lvl_i[p];
      image_o[p*FIELD_W + PU_DIS_BIT] = cfg_i[p].pu_dis;
    end
  end
endmodule

// File: rtl/gpio_mask_reg.sv
module gpio_mask_reg
  import gpio_ctl_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 2,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                rd_en_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_pu_en_o
);
  localparam int unsigned USED_W = NUM_PINS * FIELD_W;

  pin_cfg_t [NUM_PINS-1:0] cfg;
  logic     [NUM_PINS-1:0] lvl_sync;
  logic     [DATA_W-1:0]   image;
  logic     [DATA_W-1:0]   rd_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_field u_field (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en_i),
      .field_i (wr_data_i[p*FIELD_W +: FIELD_W]),
      .cfg_o   (cfg[p])
    );
    // open drain: pull low only
    assign pad_oe_o[p]    = cfg[p].dir_out & ~cfg[p].val;
    assign pad_pu_en_o[p] = ~cfg[p].pu_dis;

    AST_OE_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pad_oe_o[p]) |-> $past(wr_en_i)); // R5
  end

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (lvl_sync)
  );

  gpio_rd_pack #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_pack (
    .cfg_i   (cfg),
    .lvl_i   (lvl_sync),
    .image_o (image)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= image;
  end

  assign rd_data_o = rd_q;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R8
  if (DATA_W > USED_W) begin : g_hi_chk
    AST_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_data_o[DATA_W-1:USED_W] == '0); // R7
  end
endmodule

// File: tb/gpio_mask_reg_test.sv
module gpio_mask_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [1:0]  pad_in = 2'b11;
  logic [1:0]  pad_oe;
  logic [1:0]  pad_pu_en;

  int checks = 0;
  int errors = 0;
  logic [1:0] m_dir = '0, m_val = '0, m_pu = '0;

  always #2.5 clk = ~clk;

  gpio_mask_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .pad_in_i(pad_in),
    .pad_oe_o(pad_oe), .pad_pu_en_o(pad_pu_en)
  );

  function automatic logic [31:0] exp_image(input logic [1:0] lvl);
    logic [31:0] r = '0;
    for (int p = 0; p < 2; p++) begin
      r[p*8+1] = m_dir[p];
      r[p*8+3] = m_val[p];
      r[p*8+4] = lvl[p];
      r[p*8+5] = m_pu[p];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic model_write(input logic [31:0] d);
    for (int p = 0; p < 2; p++) begin
      if (d[p*8+0]) m_dir[p] = d[p*8+1];
      if (d[p*8+2]) m_val[p] = d[p*8+3];
      if (d[p*8+0] || d[p*8+2]) m_pu[p] = d[p*8+5];
    end
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = $urandom;
    model_write(d);
  endtask

  task automatic do_read(output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic check_pins(input string tag);
    chk({tag, " R5 oe"}, {30'd0, pad_oe}, {30'd0, m_dir & ~m_val});
    chk({tag, " R4 pu"}, {30'd0, pad_pu_en}, {30'd0, ~m_pu});
  endtask

  task automatic settle_and_read(input string tag);
    logic [31:0] v;
    repeat (2) @(negedge clk);
    do_read(v);
    chk({tag, " R6 R7 image"}, v, exp_image(pad_in));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] d;
    logic [31:0] hold;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", {30'd0, pad_oe}, 32'd0);
    chk("R1 pu", {30'd0, pad_pu_en}, 32'd3);
    chk("R8 rd reset", rd_data, 32'd0);
    rst_n = 1'b1;
    pad_in = 2'b10;
    settle_and_read("R1");

    // drive clock pin low, data untouched (R2 R3 R9)
    do_write(32'h0000_0007 | 32'h0000_2800);
    check_pins("R2 R3 R9 pull0");
    settle_and_read("R9");
    // release clock pin: direction only
    do_write(32'h0000_0001);
    check_pins("R2 release");
    // value-only write on data pin
    do_write(32'h0000_0c00);
    check_pins("R3 val only");
    // pull-up disable needs a mask
    do_write(32'h0000_2020);
    check_pins("R4 no mask");
    do_write(32'h0000_2101);
    check_pins("R4 with mask");
    settle_and_read("R4");

    // R7: all ones, input bit position must stay pad level
    pad_in = 2'b00;
    do_write(32'hffff_ffff);
    check_pins("R7 all ones");
    settle_and_read("R7");

    // R6: level read regardless of drive, latency
    pad_in = 2'b11;
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R6 early", rd_data, exp_image(2'b00));
    settle_and_read("R6");

    // R8 hold without strobe
    do_read(v);
    hold = v;
    pad_in = 2'b01;
    do_write(32'h0000_0505);
    repeat (3) @(negedge clk);
    chk("R8 hold", rd_data, hold);

    // random
    for (int i = 0; i < 300; i++) begin
      d = $urandom;
      pad_in = 2'($urandom);
      do_write(d);
      check_pins("rand R2 R3 R4 R5 R9");
      if (i % 4 == 0) settle_and_read("rand");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule